// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiply Unit

This unit executes the multiply group of an 8-bit processor's instruction set. It takes the 16-bit instruction word and decodes it without a clock edge into one of six arithmetic modes and two register indices. The register file reads the two operand bytes at those indices in the same cycle. When the start strobe is high, the unit captures the operands and the mode. One clock later it presents a 16-bit product for write-back, with the low byte going to register 0 and the high byte to register 1. It also presents new zero and carry flags and raises a one-cycle done pulse.

The six modes come from three signedness pairings: unsigned by unsigned, signed by signed, and a signed destination operand by an unsigned source operand. Each pairing has a plain form and a fractional form, and the fractional form doubles the product. Only the two flags the unit drives are affected. The processor keeps every other status bit unchanged.

Top module: `mul8_unit`

## Requirements
- R1: A word whose bits 15:10 are 100111 selects unsigned by unsigned multiply. The destination index is bits 8:4 and the source index is {bit 9, bits 3:0}, so all 32 registers can be reached.
- R2: A word whose high byte is 0x02 selects signed by signed multiply. The destination index is 16 plus bits 7:4 and the source index is 16 plus bits 3:0.
- R3: A word whose high byte is 0x03 selects a mode from {bit 7, bit 3}: 00 is signed by unsigned, 01 is fractional unsigned, 10 is fractional signed and 11 is fractional signed by unsigned. The destination index is 16 plus bits 6:4 and the source index is 16 plus bits 2:0.
- R4: In both signed by unsigned modes, the destination operand (opa_i) is read as two's complement and the source operand (opb_i) as unsigned.
- R5: Fractional modes shift the 16-bit two's complement product left by one bit. The bit shifted out of position 15 is lost.
- R6: z_o is 1 exactly when the 16-bit result is zero, and c_o equals bit 15 of that result.
- R7: A start accepted at clock edge N gives done_o high for exactly one cycle after edge N+1. prod_o, z_o and c_o are valid at that point and keep their values until the next result.
- R8: A start strobe at the edge that follows an accepted start is ignored. It produces no extra done pulse and does not change the result.
- R9: A start strobe with a word outside the multiply encodings is ignored: done_o stays low and prod_o, z_o and c_o keep their values. For such a word both index outputs are 0.
- R10: After a synchronous active-low reset, done_o, prod_o, z_o and c_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled with insn_i and the operands |
| insn_i | input | 16 | Instruction word |
| opa_i | input | 8 | Value of the register at dst_idx_o |
| opb_i | input | 8 | Value of the register at src_idx_o |
| dst_idx_o | output | 5 | Destination operand register index |
| src_idx_o | output | 5 | Source operand register index |
| prod_o | output | 16 | Product: bits 7:0 go to register 0, bits 15:8 to register 1 |
| z_o | output | 1 | Zero flag for the result |
| c_o | output | 1 | Carry flag (result bit 15) |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench builds the unit with its default 8-bit operand width, which gives a 16-bit product and 5-bit register indices. At this width the sign-boundary operands 0x80 and 0xFF, and products that overflow when doubled, can all be reached directly in every mode. The bench also sends a strobe during the busy cycle and strobes with non-multiply words, and it checks that the outputs stay unchanged afterwards.

// File: rtl/mul8_pkg.sv
// Shared types for the multiply unit.
// Assumes nothing beyond the mode list below.
package mul8_pkg;
    typedef enum logic [2:0] {
        MODE_UU,   // unsigned x unsigned
        MODE_SS,   // signed x signed
        MODE_SU,   // signed dest x unsigned src
        MODE_FUU,  // fractional unsigned
        MODE_FSS,  // fractional signed
        MODE_FSU   // fractional signed x unsigned
    } mul_mode_e;

    // True when the mode treats the destination operand as two's complement.
    function automatic logic dst_signed(input mul_mode_e m);
        return (m == MODE_SS) || (m == MODE_SU) || (m == MODE_FSS) || (m == MODE_FSU);
    endfunction

    // True when the mode treats the source operand as two's complement.
    function automatic logic src_signed(input mul_mode_e m);
        return (m == MODE_SS) || (m == MODE_FSS);
    endfunction

    // True when the mode doubles the product.
    function automatic logic is_frac(input mul_mode_e m);
        return (m == MODE_FUU) || (m == MODE_FSS) || (m == MODE_FSU);
    endfunction
endpackage

// File: rtl/mul8_decode.sv
// Instruction decoder for the multiply group.
// Purely combinational. It assumes a 16-bit word and a 32-entry register
// file; the bit positions are fixed by the instruction encoding.
module mul8_decode
    import mul8_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [15:0]      insn,
    output logic             is_mul,
    output mul_mode_e        mode,
    output logic [IDX_W-1:0] dst_idx,
    output logic [IDX_W-1:0] src_idx
);
    localparam logic [IDX_W-1:0] HI_BASE = IDX_W'(16);

    logic hit_uu, hit_ss, hit_mix;

    // Recognise the three encoding groups.
    always_comb begin
        hit_uu  = (insn[15:10] == 6'b100111);
        hit_ss  = (insn[15:8] == 8'h02);
        hit_mix = (insn[15:8] == 8'h03);
    end

    // Pick the mode and the register index fields.
    always_comb begin
        is_mul  = hit_uu | hit_ss | hit_mix;
        mode    = MODE_UU;
        dst_idx = '0;
        src_idx = '0;
        if (hit_uu) begin
            dst_idx = IDX_W'(insn[8:4]);
            src_idx = IDX_W'({insn[9], insn[3:0]});
        end else if (hit_ss) begin
            mode    = MODE_SS;
            dst_idx = HI_BASE + IDX_W'(insn[7:4]);
            src_idx = HI_BASE + IDX_W'(insn[3:0]);
        end else if (hit_mix) begin
            case ({insn[7], insn[3]})
                2'b00:   mode = MODE_SU;
                2'b01:   mode = MODE_FUU;
                2'b10:   mode = MODE_FSS;
                default: mode = MODE_FSU;
            endcase
            dst_idx = HI_BASE + IDX_W'(insn[6:4]);
            src_idx = HI_BASE + IDX_W'(insn[2:0]);
        end
    end
endmodule

// File: rtl/mul8_core.sv
// Multiply datapath: extends the operands as the mode requires, multiplies
// modulo 2^PROD_W, optionally doubles, and derives the two flags.
// Combinational; assumes the caller registers the result.
module mul8_core
    import mul8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  mul_mode_e           mode,
    output logic [2*DATA_W-1:0] prod,
    output logic                zero,
    output logic                carry
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = PROD_W - DATA_W;

    logic [PROD_W-1:0] a_ext, b_ext, raw;

    // Sign- or zero-extend the operands to the product width.
    always_comb begin
        a_ext = {{EXT_W{dst_signed(mode) & a[DATA_W-1]}}, a};
        b_ext = {{EXT_W{src_signed(mode) & b[DATA_W-1]}}, b};
    end

    // Multiply, apply the fractional shift, derive Z and C.
    always_comb begin
        raw   = a_ext * b_ext;
        prod  = is_frac(mode) ? {raw[PROD_W-2:0], 1'b0} : raw;
        zero  = (prod == '0);
        carry = prod[PROD_W-1];
    end
endmodule

// File: rtl/mul8_unit.sv
// Two-cycle multiply unit. Cycle 1 captures the operands and the mode
// (with the indices decoded combinationally so the register file can
// supply the operands in that same cycle). Cycle 2 computes and registers
// the result and pulses done. It assumes the register file presents
// opa_i/opb_i for the indices it is given, in the same cycle.
module mul8_unit
    import mul8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [15:0]         insn_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    output logic [IDX_W-1:0]    dst_idx_o,
    output logic [IDX_W-1:0]    src_idx_o,
    output logic [2*DATA_W-1:0] prod_o,
    output logic                z_o,
    output logic                c_o,
    output logic                done_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic              dec_mul;
    mul_mode_e         dec_mode;
    logic              accept;
    logic              busy_q;
    mul_mode_e         mode_q;
    logic [DATA_W-1:0] a_q, b_q;
    logic [PROD_W-1:0] core_prod;
    logic              core_zero, core_carry;
    logic [PROD_W-1:0] prod_q;
    logic              z_q, c_q, done_q;

    mul8_decode #(.IDX_W(IDX_W)) u_dec (
        .insn    (insn_i),
        .is_mul  (dec_mul),
        .mode    (dec_mode),
        .dst_idx (dst_idx_o),
        .src_idx (src_idx_o)
    );

    // Accept a strobe only for a multiply word while idle.
    always_comb accept = start_i & dec_mul & ~busy_q;

    // Stage 1: hold operands and mode for the compute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mode_q <= MODE_UU;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            busy_q <= accept;
            if (accept) begin
                mode_q <= dec_mode;
                a_q    <= opa_i;
                b_q    <= opb_i;
            end
        end
    end

    mul8_core #(.DATA_W(DATA_W)) u_core (
        .a     (a_q),
        .b     (b_q),
        .mode  (mode_q),
        .prod  (core_prod),
        .zero  (core_zero),
        .carry (core_carry)
    );

    // Stage 2: register the result and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            z_q    <= 1'b0;
            c_q    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= busy_q;
            if (busy_q) begin
                prod_q <= core_prod;
                z_q    <= core_zero;
                c_q    <= core_carry;
            end
        end
    end

    // Drive the outputs from the result registers.
    always_comb begin
        prod_o = prod_q;
        z_o    = z_q;
        c_o    = c_q;
        done_o = done_q;
    end
endmodule

// File: rtl/mul8_unit_chk.sv
// Property checker for mul8_unit, attached by bind below.
module mul8_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [15:0] insn_i,
    input logic [4:0]  dst_idx_o,
    input logic [4:0]  src_idx_o,
    input logic [15:0] prod_o,
    input logic        z_o,
    input logic        c_o,
    input logic        done_o,
    input logic        busy_q
);
    logic word_is_mul;
    always_comb word_is_mul = (insn_i[15:10] == 6'b100111) || (insn_i[15:9] == 7'b0000001);

    a_r2_idx_band: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[15:8] == 8'h02) |-> (dst_idx_o[4] && src_idx_o[4]));

    a_r3_idx_band: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[15:8] == 8'h03) |-> (dst_idx_o[4:3] == 2'b10 && src_idx_o[4:3] == 2'b10));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (z_o == (prod_o == 16'h0000)));

    a_r6_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (c_o == prod_o[15]));

    a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && word_is_mul && !busy_q) |=> ##1 done_o);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(prod_o)));

    a_r9_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !word_is_mul |-> (dst_idx_o == 5'd0 && src_idx_o == 5'd0));
endmodule

bind mul8_unit mul8_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .insn_i    (insn_i),
    .dst_idx_o (dst_idx_o),
    .src_idx_o (src_idx_o),
    .prod_o    (prod_o),
    .z_o       (z_o),
    .c_o       (c_o),
    .done_o    (done_o),
    .busy_q    (busy_q)
);

// File: tb/mul8_unit_test.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares on every done pulse.
module mul8_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] insn_i = 16'h0000;
    logic [7:0]  opa_i = 8'h00, opb_i = 8'h00;
    logic [4:0]  dst_idx_o, src_idx_o;
    logic [15:0] prod_o;
    logic        z_o, c_o, done_o;

    int total = 0;
    int bad = 0;
    int dones = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] p;
        logic        z;
        logic        c;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mul8_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .opa_i(opa_i), .opb_i(opb_i), .dst_idx_o(dst_idx_o), .src_idx_o(src_idx_o),
        .prod_o(prod_o), .z_o(z_o), .c_o(c_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference result from the requirements.
    function automatic exp_t model(input logic [15:0] w, input logic [7:0] a, input logic [7:0] b);
        int sa, sb_v, p;
        bit fr;
        exp_t e;
        sa = int'(a); sb_v = int'(b); fr = 1'b0; e.tag = "R1";
        if (w[15:8] == 8'h02) begin
            sa = int'($signed(a)); sb_v = int'($signed(b)); e.tag = "R2";
        end else if (w[15:8] == 8'h03) begin
            case ({w[7], w[3]})
                2'b00: begin sa = int'($signed(a)); e.tag = "R4"; end
                2'b01: begin fr = 1'b1; e.tag = "R5"; end
                2'b10: begin sa = int'($signed(a)); sb_v = int'($signed(b)); fr = 1'b1; e.tag = "R5"; end
                default: begin sa = int'($signed(a)); fr = 1'b1; e.tag = "R4/R5"; end
            endcase
        end
        p = sa * sb_v;
        if (fr) p = p * 2;
        e.p = p[15:0];
        e.z = (e.p == 16'h0000);
        e.c = e.p[15];
        return e;
    endfunction

    function automatic logic [9:0] exp_idx(input logic [15:0] w);
        if (w[15:10] == 6'b100111) return {w[8:4], w[9], w[3:0]};
        if (w[15:8] == 8'h02) return {1'b1, w[7:4], 1'b1, w[3:0]};
        if (w[15:8] == 8'h03) return {2'b10, w[6:4], 2'b10, w[2:0]};
        return 10'd0;
    endfunction

    // Word builders per encoding.
    function automatic logic [15:0] w_uu(input logic [4:0] d, input logic [4:0] r);
        return 16'h9C00 | (16'(r[4]) << 9) | (16'(d) << 4) | 16'(r[3:0]);
    endfunction
    function automatic logic [15:0] w_ss(input logic [3:0] d, input logic [3:0] r);
        return 16'h0200 | (16'(d) << 4) | 16'(r);
    endfunction
    function automatic logic [15:0] w_mx(input logic [1:0] sel, input logic [2:0] d, input logic [2:0] r);
        return 16'h0300 | (16'(sel[1]) << 7) | (16'(sel[0]) << 3) | (16'(d) << 4) | 16'(r);
    endfunction

    // Driver: one complete multiply, with index checks in the start cycle.
    task automatic issue(input logic [15:0] w, input logic [7:0] a, input logic [7:0] b, input string itag);
        logic [9:0] ix;
        exp_t e;
        @(negedge clk);
        insn_i = w; opa_i = a; opb_i = b; start_i = 1'b1;
        #1;
        ix = exp_idx(w);
        check(dst_idx_o == ix[9:5], {itag, " dst index"}, 32'(dst_idx_o), 32'(ix[9:5]));
        check(src_idx_o == ix[4:0], {itag, " src index"}, 32'(src_idx_o), 32'(ix[4:0]));
        e = model(w, a, b);
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R7 done after two edges", 32'(done_o), 32'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
        check(prod_o == e.p, "R7 result held", 32'(prod_o), 32'(e.p));
    endtask

    // Monitor: compare each done pulse with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t e;
            dones++;
            if (sb.size() == 0) begin
                check(1'b0, "R8/R9 unexpected done", 32'(prod_o), 32'd0);
            end else begin
                e = sb.pop_front();
                check(prod_o == e.p, {e.tag, " product"}, 32'(prod_o), 32'(e.p));
                check(z_o == e.z, {e.tag, " R6 zero flag"}, 32'(z_o), 32'(e.z));
                check(c_o == e.c, {e.tag, " R6 carry flag"}, 32'(c_o), 32'(e.c));
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d0;
        logic [15:0] p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(done_o == 1'b0, "R10 done", 32'(done_o), 32'd0);
        check(prod_o == 16'h0, "R10 prod", 32'(prod_o), 32'd0);
        check({z_o, c_o} == 2'b00, "R10 flags", 32'({z_o, c_o}), 32'd0);

        // R1 unsigned, full index range
        issue(w_uu(5'd31, 5'd17), 8'hFF, 8'hFF, "R1");
        issue(w_uu(5'd0, 5'd5), 8'h00, 8'h5A, "R1");
        issue(w_uu(5'd9, 5'd30), 8'h80, 8'h02, "R1");
        // R2 signed x signed
        issue(w_ss(4'd15, 4'd0), 8'h80, 8'h80, "R2");
        issue(w_ss(4'd3, 4'd12), 8'hFF, 8'h01, "R2");
        // R3/R4 signed x unsigned
        issue(w_mx(2'b00, 3'd7, 3'd2), 8'hFF, 8'hFF, "R3/R4");
        // R3/R5 fractional modes
        issue(w_mx(2'b01, 3'd1, 3'd6), 8'h80, 8'h80, "R3/R5");
        issue(w_mx(2'b01, 3'd4, 3'd4), 8'hFF, 8'hFF, "R3/R5");
        issue(w_mx(2'b10, 3'd0, 3'd7), 8'h80, 8'h80, "R3/R5");
        issue(w_mx(2'b11, 3'd5, 3'd3), 8'h80, 8'hFF, "R3/R4/R5");

        // Mixed patterns across all encodings
        for (int i = 0; i < 40; i++) begin
            logic [15:0] w;
            case (i % 4)
                0: w = w_uu(5'($urandom), 5'($urandom));
                1: w = w_ss(4'($urandom), 4'($urandom));
                default: w = w_mx(2'($urandom), 3'($urandom), 3'($urandom));
            endcase
            issue(w, 8'($urandom), 8'($urandom), "R1/R2/R3");
        end

        // R8: strobe held into the busy cycle with another word
        d0 = dones;
        @(negedge clk);
        insn_i = w_uu(5'd2, 5'd3); opa_i = 8'h10; opb_i = 8'h10; start_i = 1'b1;
        sb.push_back(model(w_uu(5'd2, 5'd3), 8'h10, 8'h10));
        @(negedge clk);
        insn_i = w_ss(4'd1, 4'd1); opa_i = 8'h7F; opb_i = 8'h7F;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(dones - d0 == 1, "R8 single done", 32'(dones - d0), 32'd1);
        check(prod_o == 16'h0100, "R8 result of first", 32'(prod_o), 32'h0100);

        // R9: non-multiply words are ignored
        d0 = dones;
        p0 = prod_o;
        @(negedge clk);
        insn_i = 16'h0C12; opa_i = 8'h33; opb_i = 8'h44; start_i = 1'b1;
        #1;
        check({dst_idx_o, src_idx_o} == 10'd0, "R9 indices zero", 32'({dst_idx_o, src_idx_o}), 32'd0);
        @(negedge clk);
        insn_i = 16'h0400;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(dones == d0, "R9 no done", 32'(dones - d0), 32'd0);
        check(prod_o == p0, "R9 prod held", 32'(prod_o), 32'(p0));
        check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule